// File: doc/BRIEF.md
# SPMI Command Front-End

This block sits between an APB register port and a serial power-management bus engine, and serves one channel. Software fills up to four 32-bit write-data words. It then writes one command word that starts a transaction. The block turns that word into a single valid/ready request to the engine. The request carries the opcode, slave ID, register address, byte count and 128 bits of write data. When the engine answers, the block records completion and failure for the slave that was addressed. For read opcodes it also keeps the returned bytes in a read bank owned by that slave.

Bytes are packed big-endian. The first byte on the bus occupies the top byte of the first word. A short final word keeps only its upper bytes, and the block forces every byte beyond the count to zero, in both directions. All register offsets are shifted by 0x300 times the static `CHANNEL` parameter. Only one transaction is in flight at a time. From the start until the response, bit 31 of the command register reads as busy.

Top module: `spmi_cmd_frontend`

## Requirements
- R1: An APB write to offset 0x100 that has bit 31 set starts a transaction when the block is idle and the opcode in bits 27:24 is below 11. The request then carries opcode = bits 27:24, length = bits 23:20 (byte count minus one), slave = bits 19:16 and address = bits 15:0. `reqValid` stays high with these fields unchanged until the cycle after `reqReady` is seen.
- R2: Write-data words sit at offsets 0x104, 0x108, 0x10C and 0x110 and read back what was written. `reqWdata` is {word0, word1, word2, word3}, so transfer byte k sits at bits 127-8k down to 120-8k. Bytes with k greater than the length field are zero.
- R3: Bit 31 of the command register reads 1 from the cycle after a start until the response arrives. While it is 1, writes to the command register and to the write-data words have no effect.
- R4: A start clears the done and fail bits of the addressed slave.
- R5: Each slave s has a status word at offset 0x200 + 0x20*s. Bit 0 is done and bit 2 is fail; all other bits read 0. A response sets done and copies `rspErr` into fail. Fail is never set while done is clear.
- R6: A read opcode (2, 4 or 6) whose response has no error stores `rspRdata` into slave s's words at 0x204 + 0x20*s + 4*j, where word j = bits 127-32j down to 96-32j. Bytes beyond the count read as zero. A write opcode or an error response leaves the bank unchanged.
- R7: A started opcode of 11 or above issues no request, never raises busy, and sets both done and fail for that slave on the next cycle.
- R8: A command write with bit 31 clear starts nothing and changes no status.
- R9: Every offset is shifted by 0x300*CHANNEL. Reads of any offset that is not mapped return 0. Writes to status and read-data words are ignored.
- R10: `pReady` is always 1, so every APB access completes with zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pSel | input | 1 | APB select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB write when 1 |
| pAddr | input | 16 | APB byte address |
| pWdata | input | 32 | APB write data |
| pRdata | output | 32 | APB read data |
| pReady | output | 1 | APB ready, tied high |
| reqValid | output | 1 | Request to the bus engine is valid |
| reqReady | input | 1 | Bus engine accepts the request |
| reqOp | output | 4 | Request opcode |
| reqSid | output | 4 | Request slave ID |
| reqAddr | output | 16 | Request register address |
| reqLen | output | 4 | Request byte count minus one |
| reqWdata | output | 128 | Request write data, big-endian, masked to the count |
| rspValid | input | 1 | Engine response strobe |
| rspRdata | input | 128 | Response data, big-endian |
| rspErr | input | 1 | Response failed |

## Verification
The properties assume that the engine raises `rspValid` only after it has taken the request, and only once per request. They also assume that `reqReady` is read only while a request is pending, and that APB access phases follow a setup phase. The behavioural responder in the bench follows these rules. It waits a set delay after seeing `reqValid` and pulses `reqReady` for one cycle. It then waits a second delay and returns exactly one one-cycle response. The delays are chosen so that the busy-phase register accesses fall between the start and the response.

// File: rtl/spmi_fe_pkg.sv
package spmi_fe_pkg;
  localparam int ADDR_W   = 16;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 4;
  localparam int BUS_W    = WORD_W * N_WORDS;
  localparam int BYTES    = BUS_W / 8;
  localparam int SID_W    = 4;
  localparam int N_SLAVES = 1 << SID_W;
  localparam int OP_W     = 4;
  localparam int LEN_W    = 4;
  localparam int REG_W    = 16;
  localparam int IDX_W    = $clog2(N_WORDS);
  localparam int N_OPS    = 11;

  // command word field positions
  localparam int GO_BIT   = 31;
  localparam int OP_LSB   = 24;
  localparam int LEN_LSB  = 20;
  localparam int SID_LSB  = 16;
  localparam int ADR_LSB  = 0;

  localparam logic [ADDR_W-1:0] CMD_OFS  = 16'h0100;
  localparam logic [ADDR_W-1:0] WD_OFS   = 16'h0104;
  localparam logic [ADDR_W-1:0] BANK_OFS = 16'h0200;
  localparam int BANK_SPAN   = N_SLAVES * 32;
  localparam int CHAN_STRIDE = 'h300;

  typedef struct packed {
    logic             cmd;
    logic             wd;
    logic             stat;
    logic             rd;
    logic [IDX_W-1:0] word;
    logic [SID_W-1:0] sid;
  } hit_t;

  typedef struct packed {
    logic             start;
    logic             badOp;
    logic             wdWr;
    logic [IDX_W-1:0] wdIdx;
    logic             rspDone;
    logic             rspErr;
    logic             keepRd;
  } strobe_t;

  function automatic hit_t decodeAddr(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] rel, sub, w;
    logic [4:0] low, lw;
    hit_t h;
    h   = '0;
    rel = addr - base;
    sub = rel - BANK_OFS;
    w   = rel - WD_OFS;
    low = sub[4:0];
    lw  = low - 5'd4;
    if (rel == CMD_OFS) begin
      h.cmd = 1'b1;
    end else if (rel >= WD_OFS && rel < WD_OFS + ADDR_W'(4 * N_WORDS) && rel[1:0] == 2'b00) begin
      h.wd   = 1'b1;
      h.word = w[2 +: IDX_W];
    end else if (rel >= BANK_OFS && rel < BANK_OFS + ADDR_W'(BANK_SPAN)) begin
      h.sid = sub[5 +: SID_W];
      if (low == 5'd0) begin
        h.stat = 1'b1;
      end else if (low[1:0] == 2'b00 && low <= 5'(4 * N_WORDS)) begin
        h.rd   = 1'b1;
        h.word = lw[2 +: IDX_W];
      end
    end
    return h;
  endfunction

  function automatic logic [BUS_W-1:0] keepMask(input logic [LEN_W-1:0] lenM1);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (k <= int'(lenM1)) m[BUS_W-1-8*k -: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic isReadOp(input logic [OP_W-1:0] op);
    return (op == 4'd2) || (op == 4'd4) || (op == 4'd6);
  endfunction
endpackage

// File: rtl/spmi_fe_ctrl.sv
module spmi_fe_ctrl
  import spmi_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pSel,
  input  logic             pEnable,
  input  logic             pWrite,
  input  logic             hitCmd,
  input  logic             hitWd,
  input  logic [IDX_W-1:0] hitWord,
  input  logic             cmdGo,
  input  logic [OP_W-1:0]  cmdOp,
  input  logic [OP_W-1:0]  curOp,
  input  logic             reqReady,
  input  logic             rspValid,
  input  logic             rspErr,
  output strobe_t          strb,
  output logic             reqValid,
  output logic             busy
);
  typedef enum logic [1:0] {IDLE, REQ, WAIT} state_t;
  state_t state;

  logic wrAcc, cmdFire, rspTake;

  assign wrAcc   = pSel && pEnable && pWrite;
  assign cmdFire = wrAcc && hitCmd && cmdGo && !busy;
  assign rspTake = (state == WAIT) && rspValid;
  assign busy     = (state != IDLE);
  assign reqValid = (state == REQ);

  always_comb begin
    strb         = '0;
    strb.start   = cmdFire && (cmdOp <  OP_W'(N_OPS));
    strb.badOp   = cmdFire && (cmdOp >= OP_W'(N_OPS));
    strb.wdWr    = wrAcc && hitWd && !busy;
    strb.wdIdx   = hitWord;
    strb.rspDone = rspTake;
    strb.rspErr  = rspErr;
    strb.keepRd  = rspTake && !rspErr && isReadOp(curOp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
    end else begin
      case (state)
        IDLE:    if (strb.start) state <= REQ;
        REQ:     if (reqReady)   state <= WAIT;
        WAIT:    if (rspValid)   state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spmi_fe_dpath.sv
module spmi_fe_dpath
  import spmi_fe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  hit_t                hit,
  input  logic                pSel,
  input  logic                pWrite,
  input  logic [WORD_W-1:0]   pWdata,
  input  logic                busy,
  input  logic [BUS_W-1:0]    rspRdata,
  output logic [OP_W-1:0]     curOp,
  output logic [SID_W-1:0]    curSid,
  output logic [REG_W-1:0]    curAddr,
  output logic [LEN_W-1:0]    curLen,
  output logic [BUS_W-1:0]    reqWdata,
  output logic [WORD_W-1:0]   pRdata,
  output logic [N_SLAVES-1:0] statDone,
  output logic [N_SLAVES-1:0] statFail
);
  logic [WORD_W-1:0] wdReg  [N_WORDS];
  logic [BUS_W-1:0]  rdBank [N_SLAVES];
  logic [BUS_W-1:0]  wdFlat, bankSel;
  logic [SID_W-1:0]  newSid;

  assign newSid = pWdata[SID_LSB +: SID_W];

  // command latch and per-slave status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp    <= '0;
      curSid   <= '0;
      curAddr  <= '0;
      curLen   <= '0;
      statDone <= '0;
      statFail <= '0;
    end else begin
      if (strb.start || strb.badOp) begin
        curOp            <= pWdata[OP_LSB  +: OP_W];
        curLen           <= pWdata[LEN_LSB +: LEN_W];
        curSid           <= newSid;
        curAddr          <= pWdata[ADR_LSB +: REG_W];
        statDone[newSid] <= strb.badOp;
        statFail[newSid] <= strb.badOp;
      end
      if (strb.rspDone) begin
        statDone[curSid] <= 1'b1;
        statFail[curSid] <= strb.rspErr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_WORDS; i++) wdReg[i] <= '0;
    end else if (strb.wdWr) begin
      wdReg[strb.wdIdx] <= pWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_SLAVES; i++) rdBank[i] <= '0;
    end else if (strb.keepRd) begin
      rdBank[curSid] <= rspRdata & keepMask(curLen);
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_pack
    assign wdFlat[BUS_W-1-WORD_W*g -: WORD_W] = wdReg[g];
  end
  assign reqWdata = wdFlat & keepMask(curLen);

  assign bankSel = rdBank[hit.sid];

  always_comb begin
    pRdata = '0;
    if (pSel && !pWrite) begin
      if (hit.cmd)
        pRdata = WORD_W'({busy, 3'b000, curOp, curLen, curSid, curAddr});
      else if (hit.wd)
        pRdata = wdReg[hit.word];
      else if (hit.stat)
        pRdata = WORD_W'({statFail[hit.sid], 1'b0, statDone[hit.sid]});
      else if (hit.rd)
        pRdata = bankSel[BUS_W-1-WORD_W*int'(hit.word) -: WORD_W];
    end
  end
endmodule

// File: rtl/spmi_cmd_frontend.sv
module spmi_cmd_frontend
  import spmi_fe_pkg::*;
#(
  parameter int CHANNEL = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [WORD_W-1:0] pWdata,
  output logic [WORD_W-1:0] pRdata,
  output logic              pReady,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [OP_W-1:0]   reqOp,
  output logic [SID_W-1:0]  reqSid,
  output logic [REG_W-1:0]  reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic [BUS_W-1:0]  reqWdata,
  input  logic              rspValid,
  input  logic [BUS_W-1:0]  rspRdata,
  input  logic              rspErr
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CHANNEL * CHAN_STRIDE);

  hit_t                hit;
  strobe_t             strb;
  logic                busy;
  logic [OP_W-1:0]     curOp;
  logic [SID_W-1:0]    curSid;
  logic [REG_W-1:0]    curAddr;
  logic [LEN_W-1:0]    curLen;
  logic [N_SLAVES-1:0] statDone, statFail;

  assign hit    = decodeAddr(pAddr, BASE);
  assign pReady = 1'b1;

  spmi_fe_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .hitCmd(hit.cmd), .hitWd(hit.wd), .hitWord(hit.word),
    .cmdGo(pWdata[GO_BIT]), .cmdOp(pWdata[OP_LSB +: OP_W]),
    .curOp(curOp),
    .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr),
    .strb(strb), .reqValid(reqValid), .busy(busy)
  );

  spmi_fe_dpath dpath_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .hit(hit),
    .pSel(pSel), .pWrite(pWrite), .pWdata(pWdata),
    .busy(busy), .rspRdata(rspRdata),
    .curOp(curOp), .curSid(curSid), .curAddr(curAddr), .curLen(curLen),
    .reqWdata(reqWdata), .pRdata(pRdata),
    .statDone(statDone), .statFail(statFail)
  );

  assign reqOp   = curOp;
  assign reqSid  = curSid;
  assign reqAddr = curAddr;
  assign reqLen  = curLen;
endmodule

// File: rtl/spmi_fe_sva.sv
module spmi_fe_sva
  import spmi_fe_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [OP_W-1:0]     reqOp,
  input logic [SID_W-1:0]    reqSid,
  input logic [REG_W-1:0]    reqAddr,
  input logic [LEN_W-1:0]    reqLen,
  input logic [BUS_W-1:0]    reqWdata,
  input logic                rspValid,
  input logic                rspErr,
  input logic                busy,
  input logic [SID_W-1:0]    curSid,
  input logic [N_SLAVES-1:0] statDone,
  input logic [N_SLAVES-1:0] statFail
);
  // R1: a pending request holds its fields until taken
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqOp) && $stable(reqSid)
      && $stable(reqAddr) && $stable(reqLen) && $stable(reqWdata));

  // R3: busy covers the request phase
  a_r3_busy_during_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);

  // R4: a fresh request finds its slave's status cleared
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> !statDone[reqSid] && !statFail[reqSid]);

  // R5: a response after acceptance sets done and copies the error
  a_r5_rsp_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    busy && !reqValid && rspValid |=> statDone[$past(curSid)]
      && (statFail[$past(curSid)] == $past(rspErr)) && !busy);

  // R5: fail only alongside done
  a_r5_fail_implies_done: assert property (@(posedge clk) disable iff (!rstN)
    (statFail & ~statDone) == '0);

  // R7: illegal opcodes never reach the engine
  a_r7_legal_op_only: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqOp < OP_W'(N_OPS));
endmodule

bind spmi_cmd_frontend spmi_fe_sva sva_i (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqSid(reqSid), .reqAddr(reqAddr), .reqLen(reqLen),
  .reqWdata(reqWdata),
  .rspValid(rspValid), .rspErr(rspErr),
  .busy(busy), .curSid(curSid),
  .statDone(statDone), .statFail(statFail)
);

// File: tb/spmi_cmd_frontend_tb_top.sv
module spmi_cmd_frontend_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [15:0] pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic pReady;
  logic reqValid;
  logic reqReady = 1'b0;
  logic [3:0] reqOp, reqSid, reqLen;
  logic [15:0] reqAddr;
  logic [127:0] reqWdata;
  logic rspValid = 1'b0;
  logic [127:0] rspRdata = '0;
  logic rspErr = 1'b0;

  always #5 clk = ~clk;

  spmi_cmd_frontend #(.CHANNEL(1)) dut_i (
    .clk(clk), .rstN(rstN),
    .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite), .pAddr(pAddr),
    .pWdata(pWdata), .pRdata(pRdata), .pReady(pReady),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqSid(reqSid),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  // channel 1 window
  localparam logic [15:0] CMD_A = 16'h0400;
  function automatic logic [15:0] wdA(input int j); return 16'h0404 + 16'(4*j); endfunction
  function automatic logic [15:0] stA(input int s); return 16'h0500 + 16'(32*s); endfunction
  function automatic logic [15:0] rdA(input int s, input int j);
    return 16'h0504 + 16'(32*s) + 16'(4*j);
  endfunction

  int vecs = 0, errs = 0;
  bit finished = 0;

  // scoreboard queues
  logic [31:0] expData[$];
  logic [31:0] expMask[$];
  string       expTag[$];
  logic [3:0]  qOp[$], qSid[$], qLen[$];
  logic [15:0] qAddr[$];
  logic [127:0] qWd[$];

  int readyDelay = 1, rspDelay = 20;
  logic [127:0] nextRsp = '0;
  logic nextErr = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); pSel = 1; pWrite = 1; pAddr = a; pWdata = d; pEnable = 0;
    @(negedge clk); pEnable = 1;
    @(negedge clk); pSel = 0; pEnable = 0; pWrite = 0;
  endtask

  task automatic apbAccessRead(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); pSel = 1; pWrite = 0; pAddr = a; pEnable = 0;
    @(negedge clk); pEnable = 1;
    #2 d = pRdata;
    @(negedge clk); pSel = 0; pEnable = 0;
  endtask

  task automatic apbExpect(input logic [15:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    expData.push_back(e); expMask.push_back('1); expTag.push_back(tag);
    apbAccessRead(a, d);
  endtask

  task automatic apbPeek(input logic [15:0] a, output logic [31:0] d);
    expData.push_back('0); expMask.push_back('0); expTag.push_back("");
    apbAccessRead(a, d);
  endtask

  task automatic expectReq(input logic [3:0] op, input logic [3:0] sid, input logic [15:0] adr,
                           input logic [3:0] len, input logic [127:0] wd);
    qOp.push_back(op); qSid.push_back(sid); qAddr.push_back(adr);
    qLen.push_back(len); qWd.push_back(wd);
  endtask

  task automatic waitDone(input int s);
    logic [31:0] d;
    bit got = 0;
    for (int n = 0; n < 100 && !got; n++) begin
      apbPeek(stA(s), d);
      got = d[0];
    end
    check(got, "R5 done never set", {127'b0, got}, 128'd1);
  endtask

  // monitor: pops expected read values and compares
  initial forever begin
    @(negedge clk); #2;
    if (pSel && pEnable && !pWrite) begin
      if (expData.size() == 0) begin
        check(0, "R9 unexpected read", '0, '0);
      end else begin
        logic [31:0] e, m;
        string t;
        e = expData.pop_front(); m = expMask.pop_front(); t = expTag.pop_front();
        if (m != 0) check((pRdata & m) == (e & m), t, pRdata, e);
        if (m != 0) check(pReady == 1'b1, "R10 pReady low", pReady, 1);
      end
    end
  end

  // behavioural bus engine
  initial forever begin
    @(negedge clk);
    if (rstN && reqValid) begin
      if (qOp.size() == 0) begin
        check(0, "R7/R8 unexpected request", reqOp, 0);
      end else begin
        logic [3:0] eo, es, el;
        logic [15:0] ea;
        logic [127:0] ew;
        eo = qOp.pop_front(); es = qSid.pop_front(); ea = qAddr.pop_front();
        el = qLen.pop_front(); ew = qWd.pop_front();
        check(reqOp == eo && reqSid == es && reqAddr == ea && reqLen == el,
              "R1 request fields", {reqOp, reqSid, reqAddr, reqLen}, {eo, es, ea, el});
        check(reqWdata == ew, "R2 request data", reqWdata, ew);
      end
      repeat (readyDelay) @(negedge clk);
      reqReady = 1;
      @(negedge clk); reqReady = 0;
      repeat (rspDelay) @(negedge clk);
      rspValid = 1; rspRdata = nextRsp; rspErr = nextErr;
      @(negedge clk); rspValid = 0; rspErr = 0;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    check(reqValid == 0, "R1 reqValid after reset", reqValid, 0);
    apbExpect(CMD_A, 32'h0, "R3 cmd reset value");
    apbExpect(stA(0), 32'h0, "R5 status reset value");
    apbExpect(rdA(3, 0), 32'h0, "R6 read bank reset value");

    // R2: write data, readback
    apbWrite(wdA(0), 32'hAABBCCDD);
    apbWrite(wdA(1), 32'h11223344);
    apbExpect(wdA(1), 32'h11223344, "R2 write word readback");

    // R1/R2/R3: register write, 3 bytes, slave 3; busy and ignored writes
    readyDelay = 4; rspDelay = 20; nextRsp = {4{32'h5A5A5A5A}}; nextErr = 0;
    expectReq(4'd1, 4'd3, 16'h1234, 4'd2, {32'hAABBCC00, 96'h0});
    apbWrite(CMD_A, 32'h8123_1234);
    apbExpect(CMD_A, 32'h8123_1234, "R3 busy bit while pending");
    apbWrite(CMD_A, 32'h8245_1111);
    apbWrite(wdA(0), 32'hDEADBEEF);
    apbExpect(CMD_A, 32'h8123_1234, "R3 command write while busy ignored");
    apbExpect(wdA(0), 32'hAABBCCDD, "R3 write data while busy ignored");
    waitDone(3);
    apbExpect(stA(3), 32'h1, "R5 success status");
    apbExpect(rdA(3, 0), 32'h0, "R6 write opcode leaves bank");
    apbExpect(CMD_A, 32'h0123_1234, "R3 busy cleared after response");

    // R6: extended-long read, full 16 bytes, slave 5
    readyDelay = 0; rspDelay = 3;
    nextRsp = 128'h0102030405060708090A0B0C0D0E0F10; nextErr = 0;
    expectReq(4'd6, 4'd5, 16'h00A0, 4'd15, {32'hAABBCCDD, 32'h11223344, 64'h0});
    apbWrite(CMD_A, 32'h86F5_00A0);
    waitDone(5);
    apbExpect(rdA(5, 0), 32'h01020304, "R6 full read word0");
    apbExpect(rdA(5, 1), 32'h05060708, "R6 full read word1");
    apbExpect(rdA(5, 2), 32'h090A0B0C, "R6 full read word2");
    apbExpect(rdA(5, 3), 32'h0D0E0F10, "R6 full read word3");

    // R6: register read, 6 bytes, partial word
    nextRsp = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
    expectReq(4'd2, 4'd5, 16'h0042, 4'd5, {32'hAABBCCDD, 32'h11220000, 64'h0});
    apbWrite(CMD_A, 32'h8255_0042);
    waitDone(5);
    apbExpect(rdA(5, 0), 32'hF0E1D2C3, "R6 partial read word0");
    apbExpect(rdA(5, 1), 32'hB4A50000, "R6 partial read tail bytes zero");
    apbExpect(rdA(5, 2), 32'h0, "R6 partial read word2 zero");

    // R5/R6: error response on an extended read, slave 9
    nextRsp = '1; nextErr = 1;
    expectReq(4'd4, 4'd9, 16'h0007, 4'd0, {32'hAA000000, 96'h0});
    apbWrite(CMD_A, 32'h8409_0007);
    waitDone(9);
    apbExpect(stA(9), 32'h5, "R5 error status");
    apbExpect(rdA(9, 0), 32'h0, "R6 error leaves bank");

    // R7: illegal opcode 12 on slave 7
    apbWrite(CMD_A, 32'h8C07_0000);
    apbExpect(stA(7), 32'h5, "R7 illegal opcode status");
    apbExpect(CMD_A, 32'h0C07_0000, "R7 no busy for illegal opcode");
    apbExpect(stA(5), 32'h1, "R7 other slave status untouched");

    // R4: restart slave 9 clears its error status
    readyDelay = 2; rspDelay = 20; nextErr = 0; nextRsp = '0;
    expectReq(4'd3, 4'd9, 16'h0010, 4'd1, {32'hAABB0000, 96'h0});
    apbWrite(CMD_A, 32'h8319_0010);
    apbExpect(stA(9), 32'h0, "R4 start clears status");
    waitDone(9);
    apbExpect(stA(9), 32'h1, "R4 restarted slave completes");

    // R8: command write without the start bit
    apbWrite(CMD_A, 32'h0147_0055);
    repeat (5) @(negedge clk);
    apbExpect(stA(7), 32'h5, "R8 no-start write changes no status");
    apbExpect(CMD_A, 32'h0319_0010, "R8 no-start write leaves command");

    // R9: read-only and unmapped offsets, channel displacement
    apbWrite(stA(9), 32'hFFFF_FFFF);
    apbExpect(stA(9), 32'h1, "R9 status write ignored");
    apbWrite(rdA(5, 0), 32'h1234_5678);
    apbExpect(rdA(5, 0), 32'hF0E1D2C3, "R9 read-data write ignored");
    apbExpect(16'h0100, 32'h0, "R9 channel-0 offset unmapped");
    apbExpect(16'h0414, 32'h0, "R9 unmapped offset reads zero");

    repeat (30) @(negedge clk);
    check(qOp.size() == 0, "R1 expected requests outstanding", qOp.size(), 0);
    check(expData.size() == 0, "R10 reads not completed", expData.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule